// File: doc/BRIEF.md
# Control-Bus Receive Address Filter and Error-Bit Policy

This block sits behind the bit sampler of a consumer-electronics control-bus receiver. When the sampler delivers a completed header byte, the block decodes the initiator and destination logical addresses. It then decides whether the message belongs to this node, given a 15-bit own-address mask and the listen mode. While the message runs, it decides for every further byte whether this node drives the acknowledge bit. It also counts the bytes against the limit of one opcode plus fourteen operands, and flags any byte beyond that limit.

The sampler also reports timing faults on single bits: a rising edge at the wrong time, a period that is too short, and a period that is too long. For each fault the block decides whether reception stops and whether an error bit is driven on the line. Individual enables govern rising-edge and long-period faults. A broadcast rule, which can be switched off, takes precedence over those enables for broadcast messages. Short-period faults in broadcast messages are never answered while full listen mode is on.

Every decision is registered, so each output answers the strobe of the previous clock cycle. The own-address mask and the configuration bits are static levels held by the surrounding logic.

Top module: `cec_rx_filter`

## Requirements
- R1: After synchronous reset all outputs are 0. Every output reflects the strobes sampled at the previous rising clock edge, with exactly one cycle of latency.
- R2: On `hdr_valid`, the initiator address (`hdr_byte[7:4]`) appears on `initiator`. The destination is `hdr_byte[3:0]`, and destination 15 means broadcast.
- R3: A header whose destination d (0..14) has `own_mask[d]` set is accepted and acknowledged. Several mask bits may be set at once, and each of them matches.
- R4: In reduced listen mode (`listen_full`=0), a header addressed to another node is rejected. The bytes, errors and end of that message then cause no acknowledge, no error bit and no stop.
- R5: A broadcast header is accepted in both listen modes, and neither the header nor its bytes are acknowledged.
- R6: In full listen mode (`listen_full`=1), a header addressed to another node is accepted, but neither it nor its bytes are acknowledged.
- R7: Each byte of an accepted own-address message is acknowledged, and `rx_bytes` counts it. `msg_end` drops `msg_accept`, and a header followed directly by `msg_end` (ping) is accepted and acknowledged.
- R8: The sixteenth byte after the header and every byte after it is not acknowledged, is not counted past 15, and sets `overrun`. `overrun` stays set until the next header.
- R9: A rising-edge error asserts `rx_stop` and drops `msg_accept` only if `cfg_stop_rise`=1. It drives an error bit only if `cfg_stop_rise`=1 and `cfg_gen_rise`=1 (outside the broadcast rule).
- R10: A long-period error drives an error bit if `cfg_gen_long`=1 (outside the broadcast rule). It never stops reception.
- R11: For a broadcast message with `cfg_bcast_quiet`=0, a rising-edge error with `cfg_stop_rise`=1 drives an error bit even if `cfg_gen_rise`=0. A long-period error drives one even if `cfg_gen_long`=0. With `cfg_bcast_quiet`=1 these overrides do not apply.
- R12: A short-period error drives an error bit, except in a broadcast message while `listen_full`=1.
- R13: A byte that completes in the same cycle as a stopping rising-edge error is neither acknowledged nor counted.
- R14: `err_flags` records the errors seen in the current accepted message: bit 0 rising-edge, bit 1 short-period, bit 2 long-period. The flags are sticky and are cleared by the next header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Strobe: header byte complete |
| hdr_byte | input | 8 | Header byte: initiator in 7:4, destination in 3:0 |
| byte_done | input | 1 | Strobe: one further message byte complete |
| msg_end | input | 1 | Strobe: end of message |
| err_rise | input | 1 | Strobe: rising-edge timing error |
| err_short | input | 1 | Strobe: short bit period error |
| err_long | input | 1 | Strobe: long bit period error |
| own_mask | input | 15 | Bit i set: logical address i belongs to this node |
| listen_full | input | 1 | 1 = full listen mode, 0 = reduced |
| cfg_stop_rise | input | 1 | Rising-edge error stops reception |
| cfg_gen_rise | input | 1 | Rising-edge error may drive an error bit |
| cfg_gen_long | input | 1 | Long-period error drives an error bit |
| cfg_bcast_quiet | input | 1 | Disable broadcast error-bit overrides |
| msg_accept | output | 1 | Current message accepted by this node |
| ack_drive | output | 1 | Pulse: drive acknowledge for the last header or byte |
| errbit_drive | output | 1 | Pulse: drive an error bit on the line |
| rx_stop | output | 1 | Pulse: reception stopped |
| overrun | output | 1 | Byte count exceeded in this message |
| err_flags | output | 3 | Sticky error flags (long, short, rising) |
| initiator | output | 4 | Initiator address of the last header |
| rx_bytes | output | 4 | Bytes counted after the header |

## Verification
A byte completing and a stopping rising-edge error can land in the same cycle. Those two decisions compete: the acknowledge and the count would each advance, while the stop ends the message. The bench raises `byte_done` and `err_rise` together with `cfg_stop_rise` set and expects a stop pulse with no acknowledge and an unchanged byte count. A second collision raises short-period and long-period errors in one cycle; both flags must be set, and an error bit is expected if either rule asks for one.

// File: rtl/cecrx_pkg.sv
package cecrx_pkg;

    localparam int ADDR_W   = 4;
    localparam int NUM_LOG  = (1 << ADDR_W) - 1;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] initiator;
        logic [ADDR_W-1:0] dest;
        logic              bcast;
        logic              own_hit;
    } hdr_info_t;

    typedef struct packed {
        logic stop_rise;
        logic gen_rise;
        logic gen_long;
        logic bcast_quiet;
    } err_cfg_t;

    typedef struct packed {
        logic long_p;
        logic short_p;
        logic rise;
    } err_evt_t;

    typedef struct packed {
        logic drive;
        logic stop;
    } err_act_t;

    // Error-bit and stop decision for one cycle of error strobes.
    function automatic err_act_t err_decide(err_evt_t e, err_cfg_t c,
                                            logic bcast, logic full);
        err_act_t a;
        logic     bc_force;
        bc_force = bcast && !c.bcast_quiet;
        a.stop   = e.rise && c.stop_rise;
        a.drive  = (e.rise && c.stop_rise && (c.gen_rise || bc_force))
                 || (e.long_p && (c.gen_long || bc_force))
                 || (e.short_p && !(bcast && full));
        return a;
    endfunction

endpackage

// File: rtl/cecrx_hdr_decode.sv
module cecrx_hdr_decode
    import cecrx_pkg::*;
(
    input  logic [2*ADDR_W-1:0] hdr_byte,
    input  logic [NUM_LOG-1:0]  own_mask,
    output hdr_info_t           info
);
    logic [ADDR_W-1:0]  dest;
    logic [NUM_LOG-1:0] hit_vec;

    assign dest = hdr_byte[ADDR_W-1:0];

    for (genvar i = 0; i < NUM_LOG; i++) begin : g_match
        assign hit_vec[i] = own_mask[i] && (dest == ADDR_W'(i));
    end

    always_comb begin
        info.initiator = hdr_byte[2*ADDR_W-1:ADDR_W];
        info.dest      = dest;
        info.bcast     = (dest == BCAST_ADDR);
        info.own_hit   = |hit_vec;
    end
endmodule

// File: rtl/cecrx_byte_track.sv
module cecrx_byte_track #(
    parameter  int MAX_BYTES = 15,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    input  logic             own,
    output logic             ack_now,
    output logic [CNT_W-1:0] cnt,
    output logic             ovr
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);

    assign ack_now = adv && own && (cnt != LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            ovr <= 1'b0;
        end else if (adv) begin
            if (cnt == LIMIT) ovr <= 1'b1;
            else              cnt <= cnt + 1'b1;
        end
    end

    assert_ovr_on_excess_R8: assert property (@(posedge clk) disable iff (rst)
        (adv && !clear && cnt == LIMIT) |=> ovr);
endmodule

// File: rtl/cecrx_err_policy.sv
module cecrx_err_policy
    import cecrx_pkg::*;
(
    input  err_evt_t evt,
    input  err_cfg_t cfg,
    input  logic     bcast,
    input  logic     full,
    output err_act_t act
);
    always_comb begin
        act = err_decide(evt, cfg, bcast, full);
    end
endmodule

// File: rtl/cec_rx_filter.sv
module cec_rx_filter
    import cecrx_pkg::*;
#(
    parameter  int MAX_BYTES = 15,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hdr_valid,
    input  logic [7:0]         hdr_byte,
    input  logic               byte_done,
    input  logic               msg_end,
    input  logic               err_rise,
    input  logic               err_short,
    input  logic               err_long,
    input  logic [14:0]        own_mask,
    input  logic               listen_full,
    input  logic               cfg_stop_rise,
    input  logic               cfg_gen_rise,
    input  logic               cfg_gen_long,
    input  logic               cfg_bcast_quiet,
    output logic               msg_accept,
    output logic               ack_drive,
    output logic               errbit_drive,
    output logic               rx_stop,
    output logic               overrun,
    output logic [2:0]         err_flags,
    output logic [3:0]         initiator,
    output logic [CNT_W-1:0]   rx_bytes
);
    hdr_info_t dec, info_q;
    err_cfg_t  cfg;
    err_evt_t  evt;
    err_act_t  act;
    logic      active_q, accept_q, ack_q, eb_q, stop_q;
    logic [2:0] flags_q;
    logic      acc_now, adv, trk_ack;

    cecrx_hdr_decode u_dec (
        .hdr_byte (hdr_byte),
        .own_mask (own_mask),
        .info     (dec)
    );

    assign cfg = '{stop_rise: cfg_stop_rise, gen_rise: cfg_gen_rise,
                   gen_long: cfg_gen_long, bcast_quiet: cfg_bcast_quiet};
    assign evt = '{long_p: err_long, short_p: err_short, rise: err_rise};

    cecrx_err_policy u_pol (
        .evt   (evt),
        .cfg   (cfg),
        .bcast (info_q.bcast),
        .full  (listen_full),
        .act   (act)
    );

    assign acc_now = dec.bcast || dec.own_hit || listen_full;
    assign adv     = byte_done && active_q && !hdr_valid && !act.stop;

    cecrx_byte_track #(.MAX_BYTES(MAX_BYTES)) u_trk (
        .clk     (clk),
        .rst     (rst),
        .clear   (hdr_valid),
        .adv     (adv),
        .own     (info_q.own_hit),
        .ack_now (trk_ack),
        .cnt     (rx_bytes),
        .ovr     (overrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q   <= '0;
            active_q <= 1'b0;
            accept_q <= 1'b0;
            ack_q    <= 1'b0;
            eb_q     <= 1'b0;
            stop_q   <= 1'b0;
            flags_q  <= '0;
        end else begin
            ack_q  <= 1'b0;
            eb_q   <= 1'b0;
            stop_q <= 1'b0;
            if (hdr_valid) begin
                info_q   <= dec;
                accept_q <= acc_now;
                active_q <= acc_now;
                ack_q    <= dec.own_hit;
                flags_q  <= '0;
            end else if (active_q) begin
                eb_q    <= act.drive;
                stop_q  <= act.stop;
                ack_q   <= trk_ack;
                flags_q <= flags_q | {err_long, err_short, err_rise};
                if (act.stop || msg_end) begin
                    active_q <= 1'b0;
                    accept_q <= 1'b0;
                end
            end
        end
    end

    assign msg_accept   = accept_q;
    assign ack_drive    = ack_q;
    assign errbit_drive = eb_q;
    assign rx_stop      = stop_q;
    assign err_flags    = flags_q;
    assign initiator    = info_q.initiator;

    // Broadcast traffic is never acknowledged.
    assert_bcast_no_ack_R5: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> !info_q.bcast);
    // The byte that causes overrun is not acknowledged.
    assert_overrun_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> !ack_q);
    // A stop pulse always coincides with loss of acceptance.
    assert_stop_drops_accept_R9: assert property (@(posedge clk) disable iff (rst)
        stop_q |-> !accept_q);
    // Error bits only answer errors inside an active message.
    assert_errbit_in_msg_R4: assert property (@(posedge clk) disable iff (rst)
        eb_q |-> $past(active_q));
    // A pure rising-edge error bit needs the stop option.
    assert_rise_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (eb_q && !$past(err_long) && !$past(err_short)) |-> $past(cfg_stop_rise));
endmodule

// File: tb/cec_rx_filter_test.sv
module cec_rx_filter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hdr_valid = 0, byte_done = 0, msg_end = 0;
    logic       err_rise = 0, err_short = 0, err_long = 0;
    logic [7:0] hdr_byte = 0;
    logic [14:0] own_mask = 0;
    logic       listen_full = 0, cfg_stop_rise = 0, cfg_gen_rise = 0;
    logic       cfg_gen_long = 0, cfg_bcast_quiet = 0;
    logic       msg_accept, ack_drive, errbit_drive, rx_stop, overrun;
    logic [2:0] err_flags;
    logic [3:0] initiator, rx_bytes;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cec_rx_filter uut (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
        .byte_done(byte_done), .msg_end(msg_end), .err_rise(err_rise),
        .err_short(err_short), .err_long(err_long), .own_mask(own_mask),
        .listen_full(listen_full), .cfg_stop_rise(cfg_stop_rise),
        .cfg_gen_rise(cfg_gen_rise), .cfg_gen_long(cfg_gen_long),
        .cfg_bcast_quiet(cfg_bcast_quiet), .msg_accept(msg_accept),
        .ack_drive(ack_drive), .errbit_drive(errbit_drive), .rx_stop(rx_stop),
        .overrun(overrun), .err_flags(err_flags), .initiator(initiator),
        .rx_bytes(rx_bytes)
    );

    typedef struct {
        logic ack, eb, stp, acc, ovr;
        logic [2:0] fl;
        logic [3:0] ini, cnt;
        int due;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t e;

    // Reference model state
    logic m_act = 0, m_acc = 0, m_own = 0, m_bc = 0, m_ovr = 0;
    logic [2:0] m_fl = 0;
    logic [3:0] m_ini = 0, m_cnt = 0;

    task automatic step(input logic hv, input logic [7:0] hb, input logic bd,
                        input logic me, input logic er, input logic es,
                        input logic el, input string tag);
        exp_t x;
        logic stp, bcf;
        @(negedge clk);
        hdr_valid = hv; hdr_byte = hb; byte_done = bd; msg_end = me;
        err_rise = er; err_short = es; err_long = el;
        x.ack = 0; x.eb = 0; x.stp = 0;
        if (hv) begin
            m_bc  = (hb[3:0] == 4'hF);
            m_own = !m_bc && own_mask[hb[3:0]];
            m_acc = m_bc || m_own || listen_full;
            m_act = m_acc; m_cnt = 0; m_ovr = 0; m_fl = 0; m_ini = hb[7:4];
            x.ack = m_own;
        end else if (m_act) begin
            bcf  = m_bc && !cfg_bcast_quiet;
            stp  = er && cfg_stop_rise;
            x.eb = (stp && (cfg_gen_rise || bcf)) || (el && (cfg_gen_long || bcf))
                 || (es && !(m_bc && listen_full));
            m_fl = m_fl | {el, es, er};
            if (stp) begin m_act = 0; m_acc = 0; x.stp = 1; end
            if (bd && !stp) begin
                if (m_cnt == 4'd15) m_ovr = 1;
                else begin m_cnt = m_cnt + 1; x.ack = m_own; end
            end
            if (me) begin m_act = 0; m_acc = 0; end
        end
        x.acc = m_acc; x.ovr = m_ovr; x.fl = m_fl; x.ini = m_ini; x.cnt = m_cnt;
        x.due = cyc + 1; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
        hdr_valid = 0; byte_done = 0; msg_end = 0;
        err_rise = 0; err_short = 0; err_long = 0;
    endtask

    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            checks++;
            if (ack_drive !== e.ack || errbit_drive !== e.eb || rx_stop !== e.stp ||
                msg_accept !== e.acc || overrun !== e.ovr || err_flags !== e.fl ||
                initiator !== e.ini || rx_bytes !== e.cnt) begin
                errors++;
                $display("FAIL %s: got ack=%b eb=%b stop=%b acc=%b ovr=%b fl=%b ini=%h cnt=%0d exp ack=%b eb=%b stop=%b acc=%b ovr=%b fl=%b ini=%h cnt=%0d",
                    e.tag, ack_drive, errbit_drive, rx_stop, msg_accept, overrun,
                    err_flags, initiator, rx_bytes, e.ack, e.eb, e.stp, e.acc,
                    e.ovr, e.fl, e.ini, e.cnt);
            end
        end
    end

    task automatic hdr(input logic [7:0] b, input string tag);
        step(1, b, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic byt(input string tag);
        step(0, 8'h00, 1, 0, 0, 0, 0, tag);
    endtask
    task automatic fin(input string tag);
        step(0, 8'h00, 0, 1, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        checks++;
        if ({msg_accept, ack_drive, errbit_drive, rx_stop, overrun, err_flags, initiator, rx_bytes} !== '0) begin
            errors++;
            $display("FAIL R1 reset: got %b exp 0",
                {msg_accept, ack_drive, errbit_drive, rx_stop, overrun, err_flags, initiator, rx_bytes});
        end

        own_mask = 15'h0012;                 // addresses 1 and 4
        hdr(8'h31, "R2 R3 own addr 1");
        byt("R7 byte ack");
        fin("R7 end drops accept");
        hdr(8'h54, "R3 own addr 4");
        for (int i = 0; i < 3; i++) byt("R7 byte ack");
        fin("R7 end");

        hdr(8'h25, "R4 reject other");
        byt("R4 byte ignored");
        step(0, 0, 0, 0, 0, 1, 0, "R4 error ignored");
        fin("R4 end ignored");

        hdr(8'h4F, "R5 broadcast accepted");
        byt("R5 broadcast byte no ack");
        fin("R5 end");

        listen_full = 1;
        hdr(8'h27, "R6 full listen other");
        byt("R6 no ack");
        fin("R6 end");
        listen_full = 0;

        hdr(8'hA1, "R7 ping header");
        fin("R7 ping end");

        hdr(8'h31, "R8 start");
        for (int i = 0; i < 15; i++) byt("R8 counted byte");
        byt("R8 overrun byte");
        byt("R8 overrun held");
        hdr(8'h31, "R8 cleared by header");

        cfg_stop_rise = 0; cfg_gen_rise = 1;
        step(0, 0, 0, 0, 1, 0, 0, "R9 no stop option");
        cfg_stop_rise = 1; cfg_gen_rise = 0;
        step(0, 0, 0, 0, 1, 0, 0, "R9 stop no errbit");
        hdr(8'h31, "R9 restart");
        cfg_gen_rise = 1;
        step(0, 0, 0, 0, 1, 0, 0, "R9 stop with errbit");

        hdr(8'h31, "R10 start");
        cfg_gen_long = 1;
        step(0, 0, 0, 0, 0, 0, 1, "R10 long errbit");
        cfg_gen_long = 0;
        step(0, 0, 0, 0, 0, 0, 1, "R10 long no errbit");

        cfg_gen_rise = 0; cfg_bcast_quiet = 0;
        hdr(8'h3F, "R11 broadcast");
        step(0, 0, 0, 0, 0, 0, 1, "R11 long override");
        step(0, 0, 0, 0, 1, 0, 0, "R11 rise override");
        cfg_bcast_quiet = 1;
        hdr(8'h3F, "R11 broadcast quiet");
        step(0, 0, 0, 0, 0, 0, 1, "R11 quiet long");
        step(0, 0, 0, 0, 1, 0, 0, "R11 quiet rise");
        cfg_bcast_quiet = 0;

        hdr(8'h34, "R12 own");
        step(0, 0, 0, 0, 0, 1, 0, "R12 short errbit");
        hdr(8'h3F, "R12 bcast reduced");
        step(0, 0, 0, 0, 0, 1, 0, "R12 bcast short reduced");
        listen_full = 1;
        hdr(8'h3F, "R12 bcast full");
        step(0, 0, 0, 0, 0, 1, 0, "R12 bcast short full");
        listen_full = 0;

        cfg_stop_rise = 1;
        hdr(8'h31, "R13 start");
        byt("R13 first byte");
        step(0, 0, 1, 0, 1, 0, 0, "R13 byte with stop");

        hdr(8'h34, "R14 start");
        step(0, 0, 0, 0, 0, 1, 1, "R14 short+long same cycle");
        step(0, 0, 1, 0, 0, 0, 0, "R14 flags sticky");
        hdr(8'h31, "R14 cleared");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule